// File: doc/BRIEF.md
# Charge Session Enable Sequencer

This block is the supervisor for one charging session of a flash capacitor charger. It watches three digital inputs: the enable pin, a supply-valid bit from an undervoltage monitor, and a bit from the feedback comparator that says the target voltage has been reached. From them it produces three outputs. The first is a run enable for the cycle-level switching controller. The second is an active-low completion flag. The third marks the low-power standby condition.

All three inputs arrive asynchronously and pass through a chain of `SYNC_STAGES` flops. Only the synchronized enable is examined for a low-to-high edge. A session begins only when that edge is seen while the supply is valid. When the target is reached, switching halts and the completion flag goes low. The block then stays stopped until enable has been taken low and raised again. If the supply is lost mid-session, the session is aborted and a fresh enable edge is needed. Taking enable low always returns the block to standby.

The controller has four states:
- STANDBY: enable is low.
- ARMED: enable is high, but no valid edge has started a session.
- CHARGING: run is active.
- DONE: the target has been reached.

It has six named transitions:
- T_START: STANDBY to CHARGING, on an edge while the supply is valid.
- T_HOLDOFF: STANDBY to ARMED, when enable is high without a valid start.
- T_HIT: CHARGING to DONE.
- T_ABORT: CHARGING to ARMED, on supply loss.
- T_STOP: any state to STANDBY, when enable is low.
- T_STAY: no change.

Outputs depend only on the state. Reset is synchronous and active low, and it clears every flop. Enable is therefore treated as low just after reset.

Top module: `chg_session_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters STANDBY with `standby_o`=1, `run_en_o`=0 and `done_n_o`=1.
- R2: A change on any input reaches the outputs no earlier than `SYNC_STAGES`+1 rising clock edges after the edge that first samples it. With the default of 2, this is the third edge.
- R3: A low-to-high edge of synchronized enable, seen while the synchronized supply-valid bit is 1, moves STANDBY to CHARGING. In CHARGING, `run_en_o`=1.
- R4: If enable is already high when the supply becomes valid, no session starts. The block stays in ARMED with `run_en_o`=0 until enable is taken low and raised again.
- R5: In CHARGING, when the synchronized target bit is 1 (with enable high and supply valid), the block moves to DONE. In DONE, `run_en_o`=0 and `done_n_o`=0.
- R6: In DONE, the block stays stopped for as long as enable stays high, even after the target bit falls. A low-then-high toggle of enable starts a refresh session and drives `done_n_o` back to 1.
- R7: Synchronized enable low moves any state to STANDBY. In STANDBY, `standby_o`=1, `run_en_o`=0 and `done_n_o`=1. At most one of `run_en_o`, `standby_o` and (not `done_n_o`) is 1.
- R8: Loss of supply during CHARGING moves the block to ARMED, with `run_en_o`=0 and `done_n_o`=1. Restoring the supply does not restart the session; a new enable edge is required.
- R9: An enable edge seen while the supply is invalid does not start a session. The block goes to ARMED.
- R10: In CHARGING, enable low takes priority over supply loss, and supply loss takes priority over target reached.
- R11: The target bit has no effect in STANDBY or ARMED: `done_n_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chg_en_i | input | 1 | Charge enable request, asynchronous |
| supply_ok_i | input | 1 | 1 when the supply is above the lockout threshold, asynchronous |
| tgt_hit_i | input | 1 | 1 when the output has reached its target, asynchronous |
| run_en_o | output | 1 | Run enable to the switching controller |
| done_n_o | output | 1 | Active-low session-complete flag |
| standby_o | output | 1 | Low-power standby indication |

## Verification
In CHARGING, several exits can be requested in the same cycle. Enable can fall together with a target hit, and the supply can drop together with a target hit. The bench provokes each pair by changing both inputs at the same falling edge, so that they travel the synchronizers in lockstep. The outcome is judged against the priority order: standby in the first case, and ARMED with the completion flag released in the second. A behavioural model compares every output on every cycle and catches any ordering slip around these collisions.

// File: rtl/chg_session_pkg.sv
package chg_session_pkg;

    typedef enum logic [1:0] {
        ST_STANDBY  = 2'd0,
        ST_ARMED    = 2'd1,
        ST_CHARGING = 2'd2,
        ST_DONE     = 2'd3
    } sess_state_t;

    // bit positions inside the synchronized input bundle
    localparam int IDX_EN   = 0;
    localparam int IDX_OK   = 1;
    localparam int IDX_HIT  = 2;
    localparam int BUNDLE_W = 3;

endpackage

// File: rtl/chg_sync_chain.sv
module chg_sync_chain #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign sync_o = pipe_q[LAST];

endmodule

// File: rtl/chg_edge_det.sv
module chg_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic level_d;

    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level_i;
    end

    assign rise_o = level_i & ~level_d;

endmodule

// File: rtl/chg_session_fsm.sv
module chg_session_fsm
    import chg_session_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic en_rise,
    input  logic ok_s,
    input  logic hit_s,
    output logic run_en,
    output logic done_n,
    output logic standby
);
    sess_state_t state_q, state_d;

    // next-state selection; the priority order matters in CHARGING
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: begin
                if (en_rise && ok_s)  state_d = ST_CHARGING;   // T_START
                else if (en_s)        state_d = ST_ARMED;      // T_HOLDOFF
            end
            ST_ARMED: begin
                if (!en_s)            state_d = ST_STANDBY;    // T_STOP
            end
            ST_CHARGING: begin
                if (!en_s)            state_d = ST_STANDBY;    // T_STOP
                else if (!ok_s)       state_d = ST_ARMED;      // T_ABORT
                else if (hit_s)       state_d = ST_DONE;       // T_HIT
            end
            ST_DONE: begin
                if (!en_s)            state_d = ST_STANDBY;    // T_STOP
            end
            default:                  state_d = ST_STANDBY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    // outputs as a pure function of the state
    always_comb begin
        run_en  = 1'b0;
        done_n  = 1'b1;
        standby = 1'b0;
        unique case (state_q)
            ST_STANDBY:  standby = 1'b1;
            ST_ARMED:    ;
            ST_CHARGING: run_en  = 1'b1;
            ST_DONE:     done_n  = 1'b0;
            default:     standby = 1'b1;
        endcase
    end

endmodule

// File: rtl/chg_session_seq.sv
module chg_session_seq
    import chg_session_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_en_i,
    input  logic supply_ok_i,
    input  logic tgt_hit_i,
    output logic run_en_o,
    output logic done_n_o,
    output logic standby_o
);
    logic [BUNDLE_W-1:0] raw_in;
    logic [BUNDLE_W-1:0] sync_in;
    logic en_s, ok_s, hit_s, en_rise;

    always_comb begin
        raw_in          = '0;
        raw_in[IDX_EN]  = chg_en_i;
        raw_in[IDX_OK]  = supply_ok_i;
        raw_in[IDX_HIT] = tgt_hit_i;
    end

    chg_sync_chain #(
        .WIDTH  (BUNDLE_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    assign en_s  = sync_in[IDX_EN];
    assign ok_s  = sync_in[IDX_OK];
    assign hit_s = sync_in[IDX_HIT];

    chg_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (en_s),
        .rise_o  (en_rise)
    );

    chg_session_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_s    (en_s),
        .en_rise (en_rise),
        .ok_s    (ok_s),
        .hit_s   (hit_s),
        .run_en  (run_en_o),
        .done_n  (done_n_o),
        .standby (standby_o)
    );

endmodule

// File: rtl/chg_session_chk.sv
module chg_session_chk (
    input logic clk,
    input logic rst_n,
    input logic en_s,
    input logic en_rise,
    input logic ok_s,
    input logic hit_s,
    input logic run_en,
    input logic done_n,
    input logic standby
);
    AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({run_en, ~done_n, standby})); // R7

    AST_START_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> $past(en_rise && ok_s)); // R3

    AST_LOCKED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise && !ok_s) |=> !run_en); // R9

    AST_ARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !standby && done_n && en_s) |=> !run_en); // R4

    AST_HIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && en_s && ok_s && hit_s) |=> (!done_n && !run_en)); // R5

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_n && en_s) |=> !done_n); // R6

    AST_STOP_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> standby); // R7

    AST_ABORT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && en_s && !ok_s) |=> (!run_en && done_n && !standby)); // R10

endmodule

bind chg_session_seq chg_session_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_s    (en_s),
    .en_rise (en_rise),
    .ok_s    (ok_s),
    .hit_s   (hit_s),
    .run_en  (run_en_o),
    .done_n  (done_n_o),
    .standby (standby_o)
);

// File: tb/sim_chg_session_seq.sv
module sim_chg_session_seq;
    localparam int STG = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic rst_n, en, ok, hit;
    logic run, dn, sb;
    int   vectors = 0, miscompares = 0;
    bit   finished = 0;

    chg_session_seq #(.SYNC_STAGES(STG)) u0 (
        .clk(clk), .rst_n(rst_n), .chg_en_i(en), .supply_ok_i(ok),
        .tgt_hit_i(hit), .run_en_o(run), .done_n_o(dn), .standby_o(sb)
    );

    // behavioural reference: 0 standby, 1 armed, 2 charging, 3 done
    int   m_st = 0;
    logic m_prev = 1'b0;
    logic qe[$], qo[$], qh[$];
    logic se, so, sh;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_prev = 1'b0;
            qe.delete(); qo.delete(); qh.delete();
            repeat (STG) begin qe.push_back(1'b0); qo.push_back(1'b0); qh.push_back(1'b0); end
        end else begin
            se = qe[0]; so = qo[0]; sh = qh[0];
            if (!se)                         m_st = 0;
            else if (m_st == 0)              m_st = (!m_prev && so) ? 2 : 1;
            else if (m_st == 2 && !so)       m_st = 1;
            else if (m_st == 2 && sh)        m_st = 3;
            m_prev = se;
            void'(qe.pop_front()); void'(qo.pop_front()); void'(qh.pop_front());
            qe.push_back(en); qo.push_back(ok); qh.push_back(hit);
        end
    end

    task automatic check(string tag, logic act, logic exp, string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            check("R3", run, (m_st == 2), "model run_en");
            check("R5", dn,  (m_st != 3), "model done_n");
            check("R7", sb,  (m_st == 0), "model standby");
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wrap_up;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        wrap_up();
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; ok = 1'b0; hit = 1'b0;
        wait_n(3);
        check("R1", sb, 1'b1, "standby in reset");
        check("R1", run, 1'b0, "run in reset");
        check("R1", dn, 1'b1, "done_n in reset");
        rst_n = 1'b1;
        ok = 1'b1; wait_n(4);

        // A: normal start, with latency
        en = 1'b1; wait_n(2);
        check("R2", run, 1'b0, "run before latency");
        wait_n(1);
        check("R2", run, 1'b1, "run at latency");
        check("R3", sb, 1'b0, "standby while charging");

        // B: target reached
        hit = 1'b1; wait_n(3);
        check("R5", run, 1'b0, "run after hit");
        check("R5", dn, 1'b0, "done_n after hit");
        hit = 1'b0; wait_n(6);
        check("R6", dn, 1'b0, "done held while enable high");
        check("R6", run, 1'b0, "no resume while enable high");

        // C: toggle for a refresh
        en = 1'b0; wait_n(3);
        check("R7", sb, 1'b1, "standby on low enable");
        check("R7", dn, 1'b1, "done released on low enable");
        en = 1'b1; wait_n(3);
        check("R6", run, 1'b1, "refresh session runs");

        // D: standby
        en = 1'b0; wait_n(3);
        check("R7", sb, 1'b1, "standby");
        check("R7", run, 1'b0, "run off in standby");

        // E: edge during lockout
        ok = 1'b0; wait_n(4);
        en = 1'b1; wait_n(4);
        check("R9", run, 1'b0, "no start under lockout");
        check("R9", sb, 1'b0, "armed, not standby");
        ok = 1'b1; wait_n(6);
        check("R4", run, 1'b0, "no start on supply recovery");

        // F: new edge after recovery
        en = 1'b0; wait_n(4);
        en = 1'b1; wait_n(3);
        check("R4", run, 1'b1, "start on new edge");

        // supply loss mid-session
        ok = 1'b0; wait_n(3);
        check("R8", run, 1'b0, "abort on supply loss");
        check("R8", dn, 1'b1, "done not flagged on abort");
        ok = 1'b1; wait_n(5);
        check("R8", run, 1'b0, "no restart on supply return");
        en = 1'b0; wait_n(4);
        en = 1'b1; wait_n(3);
        check("R8", run, 1'b1, "restart after new edge");

        // same cycle: enable low with target hit
        en = 1'b0; hit = 1'b1; wait_n(3);
        check("R10", sb, 1'b1, "stop beats hit");
        check("R10", dn, 1'b1, "stop beats hit, done_n");
        wait_n(3);
        check("R11", dn, 1'b1, "hit ignored in standby");
        ok = 1'b0; en = 1'b1; wait_n(4);
        check("R11", dn, 1'b1, "hit ignored in armed");

        // same cycle: supply loss with target hit
        ok = 1'b1; en = 1'b0; hit = 1'b0; wait_n(4);
        en = 1'b1; wait_n(3);
        check("R3", run, 1'b1, "start before collision");
        ok = 1'b0; hit = 1'b1; wait_n(3);
        check("R10", run, 1'b0, "abort beats hit, run");
        check("R10", dn, 1'b1, "abort beats hit, done_n");
        check("R10", sb, 1'b0, "abort lands in armed");
        wait_n(2);
        wrap_up();
    end

endmodule